// File: doc/BRIEF.md
# SDRAM Column Data Pipeline

This block is the data path on the device side of a 32-bit synchronous DRAM model. A command decoder hands it read, write and precharge strobes together with a column address. It also hands over the settings held in the mode register: read latency, burst length and the single-beat write switch. The block turns each column command into a burst of beats. Write beats go straight into an attached behavioural column store under per-byte masks. Read beats travel through a latency shift pipeline and leave on a data bus with a per-lane output enable, the two halves of a tri-state pad.

Read and write masks follow different timing rules. A write mask acts on the beat being written in the cycle it is sampled. A read mask floats its lane two clocks later, whatever the read latency. A precharge that cuts a read short stops new beats at once, and the bus then floats one read latency after the precharge. A new read issued while an older burst is draining takes over the bus from its own latency point. When the single-write switch is set, writes are one beat long and reads keep the programmed burst length.

Top module: `sdr_data_path`

## Requirements
- R1: A read command sampled at clock edge k drives its first beat so that it is valid at edge k+2 when `mode_lat3`=0 and at edge k+3 when `mode_lat3`=1. Each later beat follows one clock after the one before it.
- R2: `mode_blen` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Beat i uses column ((col & ~(N-1)) | ((col+i) & (N-1))), which is a sequential count that wraps inside the aligned N-column block.
- R3: During reads, a `dm` bit sampled high at edge j floats its byte lane at edge j+2, for either latency. On that beat the lane's `dq_oe` bit is 0 and its `dq_out` byte reads 0. `dm[i]` controls byte `dq[8i+7:8i]`.
- R4: During writes, a `dm` bit that is high in the cycle of a beat keeps that byte of the addressed column unchanged in that same cycle.
- R5: The first write beat takes `dq_in` in the cycle of the write command. The remaining beats take `dq_in` on the following consecutive clocks.
- R6: A precharge sampled at edge p while a read burst is active suppresses every beat that would issue at p or later. Beats issued before p still come out, and `dq_oe` is 0 from edge p+L on, where L is the read latency.
- R7: With `mode_one_wr`=1, every write stores exactly one beat while reads keep the programmed burst length. With `mode_one_wr`=0, writes use the full burst length.
- R8: A read command issued while an earlier read burst is still active replaces it. From the new command's latency point onward, the bus carries only the new burst.
- R9: After reset, and whenever no read beat is in flight, `dq_oe` is 0 and `dq_out` is 0.
- R10: A read or precharge command ends an active write burst, and no beat from that cycle onward is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_lat3 | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks |
| mode_blen | input | 2 | Burst length code (1, 2, 4, 8 beats) |
| mode_one_wr | input | 1 | Single-beat write switch |
| rd_cmd | input | 1 | Read column command strobe |
| wr_cmd | input | 1 | Write column command strobe |
| pre_cmd | input | 1 | Precharge command strobe |
| col | input | 4 | Starting column of the command |
| dm | input | 4 | Per-byte mask, one bit per lane |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, zero on floated lanes |
| dq_oe | output | 4 | Per-lane output enable |

## Verification
Embedded properties check on every cycle that an enabled lane always traces back to a read beat issued exactly one latency earlier. They also check that no lane drives when its mask was high two clocks before, that the bus is quiet one latency after a precharge and after three idle issue cycles, that burst beats never restart out of nowhere, and that single-write mode never produces a follow-on write beat. Only the bench scenarios can show that the data carried is correct. These cover the column visit order within each burst, byte-level effects of write masks on the stored contents, the handover of the bus to a replacing read, and how many write beats actually land when a write is cut short.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

    localparam int DQ_W      = 32;
    localparam int LANE_W    = 8;
    localparam int LANES     = DQ_W / LANE_W;
    localparam int COL_W     = 4;
    localparam int RAM_DEPTH = 1 << COL_W;
    localparam int MAX_LAT   = 3;
    localparam int MASK_LAT  = 2;
    localparam int CNT_W     = 4;

    typedef enum logic [1:0] {
        BLEN_1 = 2'd0,
        BLEN_2 = 2'd1,
        BLEN_4 = 2'd2,
        BLEN_8 = 2'd3
    } blen_e;

    typedef struct packed {
        logic            vld;
        logic [DQ_W-1:0] dat;
    } rd_stage_t;

    function automatic logic [CNT_W-1:0] beats_of(blen_e code);
        return CNT_W'(1) << code;
    endfunction

    function automatic logic [COL_W-1:0] wrap_col(logic [COL_W-1:0] base,
                                                  logic [CNT_W-1:0] idx,
                                                  logic [CNT_W-1:0] beats);
        logic [COL_W-1:0] msk;
        msk = COL_W'(beats - CNT_W'(1));
        return (base & ~msk) | ((base + COL_W'(idx)) & msk);
    endfunction

endpackage

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
    import sdr_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             one_beat,
    input  blen_e            blen,
    input  logic [COL_W-1:0] col,
    output logic             beat_vld,
    output logic [COL_W-1:0] beat_col
);

    logic [COL_W-1:0] base_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] beats_q;
    logic             run_q;
    logic [CNT_W-1:0] beats_new;

    assign beats_new = one_beat ? CNT_W'(1) : beats_of(blen);
    assign beat_vld  = start | (run_q & ~stop);
    assign beat_col  = start ? col : wrap_col(base_q, idx_q, beats_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            idx_q   <= '0;
            rem_q   <= '0;
            beats_q <= CNT_W'(1);
            run_q   <= 1'b0;
        end else if (start) begin
            base_q  <= col;
            idx_q   <= CNT_W'(1);
            beats_q <= beats_new;
            rem_q   <= beats_new - CNT_W'(1);
            run_q   <= (beats_new > CNT_W'(1));
        end else if (stop) begin
            rem_q   <= '0;
            run_q   <= 1'b0;
        end else if (run_q) begin
            idx_q   <= idx_q + CNT_W'(1);
            rem_q   <= rem_q - CNT_W'(1);
            run_q   <= (rem_q > CNT_W'(1));
        end
    end

    AST_BURST_CONT: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !start) |-> $past(beat_vld)); // R5

    AST_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (one_beat && $past(one_beat) && !start) |-> !beat_vld); // R7

endmodule

// File: rtl/sdr_beh_ram.sv
module sdr_beh_ram
    import sdr_dp_pkg::*;
(
    input  logic             clk,
    input  logic [LANES-1:0] wr_be,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [COL_W-1:0] rd_col,
    output logic [DQ_W-1:0]  rd_data
);

    logic [DQ_W-1:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_be[l]) begin
                mem[wr_col][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_data = mem[rd_col];

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
    import sdr_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lat3,
    input  logic             in_vld,
    input  logic [DQ_W-1:0]  in_dat,
    input  logic [LANES-1:0] dm,
    output logic [DQ_W-1:0]  dq_out,
    output logic [LANES-1:0] dq_oe
);

    rd_stage_t        stg [MAX_LAT];
    logic [LANES-1:0] msk [MASK_LAT];
    rd_stage_t        tap;
    logic [1:0]       warm_q;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg[0] <= '0;
            msk[0] <= '0;
        end else begin
            stg[0] <= '{vld: in_vld, dat: in_dat};
            msk[0] <= dm;
        end
    end

    generate
        for (genvar s = 1; s < MAX_LAT; s++) begin : g_dstage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
        for (genvar s = 1; s < MASK_LAT; s++) begin : g_mstage
            always_ff @(posedge clk) begin
                if (rst) msk[s] <= '0;
                else     msk[s] <= msk[s-1];
            end
        end
    endgenerate

    assign tap = lat3 ? stg[MAX_LAT-1] : stg[MAX_LAT-2];

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign dq_oe[l] = tap.vld & ~msk[MASK_LAT-1][l];
            assign dq_out[l*LANE_W +: LANE_W] =
                dq_oe[l] ? tap.dat[l*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    assign armed = (warm_q == 2'd3);

    AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst || !armed)
        (!lat3 && (dq_oe != '0)) |-> $past(in_vld, 2)); // R1

    AST_LAT_THREE: assert property (@(posedge clk) disable iff (rst || !armed)
        (lat3 && (dq_oe != '0)) |-> $past(in_vld, 3)); // R1

    AST_MASK_HIZ: assert property (@(posedge clk) disable iff (rst || !armed)
        (dq_oe & $past(dm, 2)) == '0); // R3

endmodule

// File: rtl/sdr_data_path.sv
module sdr_data_path
    import sdr_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_lat3,
    input  logic [1:0]       mode_blen,
    input  logic             mode_one_wr,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             pre_cmd,
    input  logic [COL_W-1:0] col,
    input  logic [LANES-1:0] dm,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  dq_out,
    output logic [LANES-1:0] dq_oe
);

    logic             rd_vld;
    logic [COL_W-1:0] rd_col;
    logic             wr_vld;
    logic [COL_W-1:0] wr_col;
    logic [DQ_W-1:0]  ram_q;
    logic [LANES-1:0] wr_be;
    blen_e            blen;
    logic [1:0]       warm_q;
    logic             armed;

    assign blen  = blen_e'(mode_blen);
    assign wr_be = {LANES{wr_vld}} & ~dm;

    sdr_burst_gen u_rd_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_cmd),
        .stop     (wr_cmd | pre_cmd),
        .one_beat (1'b0),
        .blen     (blen),
        .col      (col),
        .beat_vld (rd_vld),
        .beat_col (rd_col)
    );

    sdr_burst_gen u_wr_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_cmd),
        .stop     (rd_cmd | pre_cmd),
        .one_beat (mode_one_wr),
        .blen     (blen),
        .col      (col),
        .beat_vld (wr_vld),
        .beat_col (wr_col)
    );

    sdr_beh_ram u_ram (
        .clk     (clk),
        .wr_be   (wr_be),
        .wr_col  (wr_col),
        .wr_data (dq_in),
        .rd_col  (rd_col),
        .rd_data (ram_q)
    );

    sdr_lat_pipe u_pipe (
        .clk    (clk),
        .rst    (rst),
        .lat3   (mode_lat3),
        .in_vld (rd_vld),
        .in_dat (ram_q),
        .dm     (dm),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    assign armed = (warm_q == 2'd3);

    AST_PRE_FLOAT_L2: assert property (@(posedge clk) disable iff (rst || !armed)
        (!mode_lat3 && $past(pre_cmd && !rd_cmd, 2)) |-> (dq_oe == '0)); // R6

    AST_PRE_FLOAT_L3: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode_lat3 && $past(pre_cmd && !rd_cmd, 3)) |-> (dq_oe == '0)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(rd_vld, 1) && !$past(rd_vld, 2) && !$past(rd_vld, 3))
        |-> (dq_oe == '0 && dq_out == '0)); // R9

    AST_WR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && !wr_cmd) |-> !wr_vld); // R10

endmodule

// File: tb/sdr_data_path_test.sv
module sdr_data_path_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_lat3 = 1'b0;
    logic [1:0]  mode_blen = 2'd3;
    logic        mode_one_wr = 1'b0;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;
    logic        pre_cmd = 1'b0;
    logic [3:0]  col = '0;
    logic [3:0]  dm = '0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic [3:0]  dq_oe;

    logic [31:0] exp_mem [16];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sdr_data_path uut (
        .clk(clk), .rst(rst), .mode_lat3(mode_lat3), .mode_blen(mode_blen),
        .mode_one_wr(mode_one_wr), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .pre_cmd(pre_cmd), .col(col), .dm(dm), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic int beats_n(int code);
        return 1 << code;
    endfunction

    function automatic int col_at(int base, int i, int n);
        return ((base & ~(n - 1)) & 15) | ((base + i) & (n - 1));
    endfunction

    function automatic logic [31:0] pat(int seed, int i);
        return 32'h9E3779B9 * (seed * 16 + i + 1) + 32'h01234567;
    endfunction

    function automatic logic [3:0] mpat(int seed, int i);
        return 4'((seed + i * 3) & 15);
    endfunction

    task automatic check(string tag, logic [3:0] eoe, logic [31:0] ed);
        n_checks++;
        if (dq_oe !== eoe || dq_out !== ed) begin
            n_errors++;
            $display("FAIL %s: oe=%h data=%h expected oe=%h data=%h",
                     tag, dq_oe, dq_out, eoe, ed);
        end
    endtask

    // R1 R2 R3 R6 R8 R9: drive a read and compare every cycle against the rules
    task automatic run_read(string tag, int c0, int stop_c, int r2, int c2,
                            int mc, logic [3:0] mv);
        int lat = mode_lat3 ? 3 : 2;
        int n   = beats_n(int'(mode_blen));
        for (int c = 0; c < 24; c++) begin
            int          j = c - lat;
            bit          v = 1'b0;
            int          a = 0;
            logic [3:0]  eo;
            logic [31:0] ed = '0;
            @(negedge clk);
            if (r2 >= 0 && j >= r2) begin
                if (j - r2 < n) begin v = 1'b1; a = col_at(c2, j - r2, n); end
            end else if (j >= 0 && j < n && (stop_c < 0 || j < stop_c)) begin
                v = 1'b1; a = col_at(c0, j, n);
            end
            eo = v ? ~((c - 2 == mc) ? mv : 4'h0) : 4'h0;
            for (int l = 0; l < 4; l++)
                if (eo[l]) ed[l*8 +: 8] = exp_mem[a][l*8 +: 8];
            check(tag, eo, ed);
            rd_cmd  = (c == 0) || (c == r2);
            col     = 4'((c == r2) ? c2 : c0);
            pre_cmd = (c == stop_c);
            dm      = (c == mc) ? mv : 4'h0;
        end
        rd_cmd = 1'b0; pre_cmd = 1'b0; dm = '0;
    endtask

    // R4 R5 R7 R10: drive a write burst and update the expected store
    task automatic run_write(int c0, int ic, int seed, bit use_mask);
        int n  = beats_n(int'(mode_blen));
        int nw = mode_one_wr ? 1 : n;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            wr_cmd = (c == 0);
            rd_cmd = (c == ic);
            col    = 4'((c == ic) ? 8 : c0);
            dq_in  = pat(seed, c);
            dm     = use_mask ? mpat(seed, c) : 4'h0;
            if (c < nw && (ic < 0 || c < ic)) begin
                int a = col_at(c0, c, n);
                for (int l = 0; l < 4; l++)
                    if (!dm[l]) exp_mem[a][l*8 +: 8] = dq_in[l*8 +: 8];
            end
        end
        @(negedge clk);
        wr_cmd = 1'b0; rd_cmd = 1'b0; dm = '0; dq_in = '0;
        repeat (12) @(negedge clk);
    endtask

    task automatic check_mem(string tag);
        logic [1:0] keep = mode_blen;
        mode_blen = 2'd3;
        run_read(tag, 0, -1, -1, 0, -100, 4'h0);
        run_read(tag, 8, -1, -1, 0, -100, 4'h0);
        mode_blen = keep;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed = 10;
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset", 4'h0, 32'h0);

        // fill the store with full bursts, no masks (R5)
        mode_blen = 2'd3;
        run_write(0, -1, 1, 1'b0);
        run_write(8, -1, 2, 1'b0);
        check_mem("R5 fill");

        // read sweep: both latencies, all lengths, all columns (R1 R2, R7 reads stay bursty)
        for (int l = 0; l < 2; l++) begin
            mode_lat3   = l[0];
            mode_one_wr = l[0];
            for (int b = 0; b < 4; b++) begin
                mode_blen = 2'(b);
                for (int c = 0; c < 16; c++)
                    run_read(l ? "R1 R2 R7" : "R1 R2", c, -1, -1, 0, -100, 4'h0);
            end
        end
        mode_one_wr = 1'b0;

        // read masks, precharge cut, replacement, for both latencies
        for (int l = 0; l < 2; l++) begin
            mode_lat3 = l[0];
            mode_blen = 2'd3;
            run_read("R3", 0, -1, -1, 0, 4, 4'b0101);
            run_read("R3", 3, -1, -1, 0, 1, 4'b1110);
            run_read("R3", 9, -1, -1, 0, 7, 4'b1000);
            run_read("R6", 0, 2, -1, 0, -100, 4'h0);
            run_read("R6", 8, 5, -1, 0, -100, 4'h0);
            mode_blen = 2'd2;
            run_read("R6", 2, 1, -1, 0, -100, 4'h0);
            mode_blen = 2'd3;
            run_read("R8", 0, -1, 2, 8, -100, 4'h0);
            run_read("R8", 4, -1, 5, 13, -100, 4'h0);
            mode_blen = 2'd1;
            run_read("R8", 6, -1, 1, 11, -100, 4'h0);
        end

        // write sweep with per-beat masks, burst and single-write modes (R4 R7)
        mode_lat3 = 1'b0;
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 4; b++) begin
                int cols [4] = '{0, 3, 6, 13};
                foreach (cols[k]) begin
                    mode_one_wr = s[0];
                    mode_blen   = 2'(b);
                    run_write(cols[k], -1, seed, 1'b1);
                    seed++;
                    check_mem(s ? "R4 R7" : "R4 R5");
                end
            end
        end
        mode_one_wr = 1'b0;

        // read command cutting a write burst short (R10)
        mode_blen = 2'd3;
        run_write(0, 3, seed, 1'b0);
        seed++;
        check_mem("R10");
        mode_lat3 = 1'b1;
        run_write(2, 5, seed, 1'b0);
        check_mem("R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule